// File: doc/BRIEF.md
# Pilot-Symbol Interpolating Channel Estimator

This block estimates the complex fading gain of a narrowband channel for every symbol of a slot, in a stream where each slot of seven symbols opens with one known pilot symbol. The upstream stage divides each pilot sample by the known pilot value before it arrives. Every pilot sample the block accepts enters an eleven-deep tap line. The tap line therefore holds the pilots of five slots before a centre slot, the centre slot itself, and five slots after it. For each beat, the 3-bit symbol position selects one set of windowed-sinc weights. The weighted sum of the tap line is the gain estimate for that symbol of the centre slot. The caller delays its data samples by the matching number of slots.

Both the real and the imaginary component pass through identical tap lines and multiply-accumulate units. They share one weight selector. The weights are computed at elaboration time from the interpolation formula. Input beats use a valid/ready handshake, and so do the estimates. There is one output register. An input beat is accepted only when that register is empty or is being drained in the same cycle. A stalled consumer therefore stalls the producer immediately, and no beat is lost or duplicated.

Top module: `pilot_interp_est`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A beat is accepted on a rising clock edge where in_valid and in_ready are both 1. The tap line shifts only on an accepted beat whose in_pilot is 1. The newest sample enters tap 0, and the oldest of the eleven is discarded. Beats with in_pilot at 0 leave the tap line unchanged.
- R3: An accepted beat produces no estimate until eleven pilot beats have been accepted since reset. The beat that carries the eleventh pilot produces the first estimate.
- R4: Position 0 is the pilot position. A beat with in_pos = 0 yields the centre tap, which is the sixth most recent pilot, sign-extended from 8.8 to 12.8.
- R5: A beat with in_pos = m, for m in 1..6, yields round((Σ s_j·c_j)/1024), rounded half toward plus infinity. Here s_j is the raw 16-bit signed sample in tap j, and t = 5 − j. The weight is c_j = round(1024 · sinc(x) · cos(π·0.25·x) / (1 − (0.5·x)²)), with x = m/7 − t and sinc(x) = sin(πx)/(πx).
- R6: A beat with in_pos = 7 yields an estimate of exactly 0 for both components.
- R7: The real and imaginary estimates are computed by the same rule from their own sample streams, with no cross-coupling.
- R8: While out_valid = 1 and out_ready = 0, in_ready is 0 and out_re and out_im hold their values.
- R9: Once the tap line is full, every accepted beat yields exactly one estimate. Estimates appear in acceptance order, with out_valid rising in the cycle after the accepting edge unless an earlier estimate is still stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept a beat this cycle |
| in_re | input | 16 | Real part of the received sample, signed 8.8 |
| in_im | input | 16 | Imaginary part of the received sample, signed 8.8 |
| in_pilot | input | 1 | Beat carries a normalised pilot sample |
| in_pos | input | 3 | Symbol position in the slot (0 = pilot, 1..6 data, 7 = null) |
| out_valid | output | 1 | Estimate present |
| out_ready | input | 1 | Consumer takes the estimate this cycle |
| out_re | output | 20 | Real gain estimate, signed 12.8 |
| out_im | output | 20 | Imaginary gain estimate, signed 12.8 |

## Verification
A tap line that shifts at the wrong moment, or in the wrong order, changes the very next estimate. A position-0 beat then shows a different pilot from the one expected. Data positions show a different weighted sum, because each weight set is asymmetric about the centre. A miscounted fill shows as an estimate one beat early or late around the eleventh pilot. A wrong weight or rounding step shows on the first estimate for the affected position. A handshake fault shows within one stalled cycle, as a changed estimate, an accepted input, or a missing or duplicated beat in the scoreboard order.

// File: rtl/pie_pkg.sv
package pie_pkg;
  localparam int SLOT_LEN  = 7;
  localparam int HALF_SPAN = 5;
  localparam int NTAPS     = 2 * HALF_SPAN + 1;
  localparam int IN_W      = 16;
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 10;
  localparam int POS_W     = 3;
  localparam int NPOS      = 1 << POS_W;
  localparam int OUT_W     = 20;
  localparam int ACC_W     = IN_W + COEF_W + $clog2(NTAPS);
  localparam int CNT_W     = $clog2(NTAPS + 1);
  localparam real PI_R     = 3.14159265358979323846;
  localparam real WIN_BETA = 0.25;

  function automatic real sin_ser(input real a);
    real term;
    real acc;
    term = a;
    acc  = a;
    for (int k = 1; k < 24; k++) begin
      term = -term * a * a / real'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic real cos_ser(input real a);
    real term;
    real acc;
    term = 1.0;
    acc  = 1.0;
    for (int k = 1; k < 28; k++) begin
      term = -term * a * a / real'((2 * k - 1) * (2 * k));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Integer weight for symbol position m and slot offset t.
  function automatic int coef_q(input int m, input int t);
    real x;
    real s;
    real w;
    real v;
    if (m == 0) return (t == 0) ? (1 << COEF_FRAC) : 0;
    if (m >= SLOT_LEN) return 0;
    x = real'(m) / real'(SLOT_LEN) - real'(t);
    // sin(pi*(m/L - t)) = (-1)^t * sin(pi*m/L)
    s = sin_ser(PI_R * real'(m) / real'(SLOT_LEN));
    if ((t % 2) != 0) s = -s;
    s = s / (PI_R * x);
    w = cos_ser(PI_R * WIN_BETA * x) / (1.0 - (2.0 * WIN_BETA * x) * (2.0 * WIN_BETA * x));
    v = s * w * real'(1 << COEF_FRAC);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction
endpackage

// File: rtl/pie_tapline.sv
module pie_tapline #(
  parameter int W = 16,
  parameter int N = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [W-1:0]        din,
  output logic [N-1:0][W-1:0] taps_nx
);
  logic [N-1:0][W-1:0] taps_q;

  always_comb begin
    taps_nx = taps_q;
    if (shift_en) begin
      taps_nx[0] = din;
      for (int i = 1; i < N; i++) taps_nx[i] = taps_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= taps_nx;
  end
endmodule

// File: rtl/pie_coef_sel.sv
module pie_coef_sel
  import pie_pkg::*;
(
  input  logic [POS_W-1:0]              pos,
  output logic [NTAPS-1:0][COEF_W-1:0]  coefs
);
  logic [COEF_W-1:0] tbl [NPOS][NTAPS];

  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    for (genvar j = 0; j < NTAPS; j++) begin : g_tap
      localparam int CQ = coef_q(p, HALF_SPAN - j);
      assign tbl[p][j] = COEF_W'(CQ);
    end
  end

  always_comb begin
    for (int j = 0; j < NTAPS; j++) coefs[j] = tbl[pos][j];
  end
endmodule

// File: rtl/pie_mac.sv
module pie_mac
  import pie_pkg::*;
(
  input  logic [NTAPS-1:0][IN_W-1:0]   taps,
  input  logic [NTAPS-1:0][COEF_W-1:0] coefs,
  output logic [OUT_W-1:0]             est
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] rnd;

  always_comb begin
    acc = '0;
    for (int j = 0; j < NTAPS; j++) begin
      acc = acc + ACC_W'($signed(taps[j])) * ACC_W'($signed(coefs[j]));
    end
    rnd = acc + ACC_W'(1 << (COEF_FRAC - 1));
    est = OUT_W'(rnd >>> COEF_FRAC);
  end
endmodule

// File: rtl/pilot_interp_est.sv
module pilot_interp_est
  import pie_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_re,
  input  logic [IN_W-1:0]  in_im,
  input  logic             in_pilot,
  input  logic [POS_W-1:0] in_pos,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_re,
  output logic [OUT_W-1:0] out_im
);
  logic                         accept;
  logic                         shift;
  logic [CNT_W-1:0]             fill_q, fill_nx;
  logic                         full_nx;
  logic                         out_valid_q;
  logic [1:0][OUT_W-1:0]        out_q;
  logic [1:0][OUT_W-1:0]        est_w;
  logic [1:0][IN_W-1:0]         comp_in;
  logic [NTAPS-1:0][COEF_W-1:0] coefs;

  assign in_ready = !out_valid_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign shift    = accept && in_pilot;
  assign comp_in[0] = in_re;
  assign comp_in[1] = in_im;

  always_comb begin
    fill_nx = fill_q;
    if (shift && (fill_q < CNT_W'(NTAPS))) fill_nx = fill_q + CNT_W'(1);
    full_nx = (fill_nx == CNT_W'(NTAPS));
  end

  pie_coef_sel u_coef (.pos(in_pos), .coefs(coefs));

  for (genvar c = 0; c < 2; c++) begin : g_comp
    logic [NTAPS-1:0][IN_W-1:0] taps_nx;
    pie_tapline #(.W(IN_W), .N(NTAPS)) u_taps (
      .clk(clk), .rst_n(rst_n), .shift_en(shift), .din(comp_in[c]), .taps_nx(taps_nx)
    );
    pie_mac u_mac (.taps(taps_nx), .coefs(coefs), .est(est_w[c]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q      <= '0;
      out_valid_q <= 1'b0;
      out_q       <= '0;
    end else begin
      fill_q <= fill_nx;
      if (accept && full_nx) begin
        out_valid_q <= 1'b1;
        out_q       <= est_w;
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_re    = out_q[0];
  assign out_im    = out_q[1];
endmodule

// File: rtl/pilot_interp_est_chk.sv
module pilot_interp_est_chk
  import pie_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_re,
  input logic [IN_W-1:0]  in_im,
  input logic             in_pilot,
  input logic [POS_W-1:0] in_pos,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_re,
  input logic [OUT_W-1:0] out_im
);
  logic             acc_b;
  logic [CNT_W-1:0] seen_q;
  logic             primed_now;

  assign acc_b = in_valid && in_ready;
  assign primed_now = (seen_q == CNT_W'(NTAPS)) ||
                      (in_pilot && seen_q == CNT_W'(NTAPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (acc_b && in_pilot && seen_q != CNT_W'(NTAPS)) seen_q <= seen_q + CNT_W'(1);
  end

  a_r3_no_early_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen_q == CNT_W'(NTAPS));

  a_r9_beat_yields_output: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_b && primed_now) |=> out_valid);

  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

  a_r8_no_accept_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r6_null_position_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_b && primed_now && in_pos == POS_W'(7)) |=> (out_re == '0 && out_im == '0));

  logic unused_ok;
  assign unused_ok = ^{in_re, in_im};
endmodule

bind pilot_interp_est pilot_interp_est_chk u_chk (.*);

// File: tb/pilot_interp_est_tb.sv
module pilot_interp_est_tb;
  import pie_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IN_W-1:0] in_re = '0;
  logic [IN_W-1:0] in_im = '0;
  logic in_pilot = 1'b0;
  logic [POS_W-1:0] in_pos = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [OUT_W-1:0] out_re;
  logic [OUT_W-1:0] out_im;

  always #10 clk = ~clk;

  pilot_interp_est u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .in_pilot(in_pilot), .in_pos(in_pos),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im)
  );

  int n_checks = 0;
  int n_fail = 0;
  int exp_re_q[$];
  int exp_im_q[$];
  int exp_pos_q[$];
  int mre[NTAPS];
  int mim[NTAPS];
  int pilots_seen = 0;
  int ready_mode = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bcoef(input int m, input int t);
    real x, v;
    if (m == 0) return (t == 0) ? 1024 : 0;
    if (m >= 7) return 0;
    x = real'(m) / 7.0 - real'(t);
    v = $sin(3.14159265358979323846 * x) / (3.14159265358979323846 * x) *
        $cos(3.14159265358979323846 * 0.25 * x) / (1.0 - (0.5 * x) * (0.5 * x)) * 1024.0;
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int predict(input int m, input bit imag);
    longint s = 0;
    for (int j = 0; j < NTAPS; j++)
      s += longint'(imag ? mim[j] : mre[j]) * longint'(bcoef(m, 5 - j));
    s = (s + 512) >>> 10;
    return int'(s);
  endfunction

  task automatic send(input int re, input int im, input bit pilot, input int pos);
    @(negedge clk);
    in_valid = 1'b1;
    in_re = IN_W'(re);
    in_im = IN_W'(im);
    in_pilot = pilot;
    in_pos = POS_W'(pos);
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    if (pilot) begin
      for (int j = NTAPS - 1; j > 0; j--) begin
        mre[j] = mre[j-1];
        mim[j] = mim[j-1];
      end
      mre[0] = re;
      mim[0] = im;
      pilots_seen++;
    end
    if (pilots_seen >= NTAPS) begin
      exp_re_q.push_back(predict(pos, 1'b0));
      exp_im_q.push_back(predict(pos, 1'b1));
      exp_pos_q.push_back(pos);
    end
  endtask

  // Monitor / scoreboard
  initial begin
    bit stalled = 1'b0;
    int held_re = 0, held_im = 0;
    forever begin
      @(negedge clk);
      out_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      #2;
      if (rst_n) begin
        if (stalled) begin
          chk(out_valid && $signed(out_re) == held_re, "R8", "held real value",
              $signed(out_re), held_re);
          chk($signed(out_im) == held_im, "R8", "held imag value", $signed(out_im), held_im);
        end
        stalled = 1'b0;
        if (out_valid) begin
          if (exp_re_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected estimate", 1, 0);
          end else if (out_ready) begin
            int er, ei, p;
            string rq;
            er = exp_re_q.pop_front();
            ei = exp_im_q.pop_front();
            p = exp_pos_q.pop_front();
            rq = (p == 0) ? "R4" : ((p == 7) ? "R6" : "R5");
            chk($signed(out_re) == er, rq, "real estimate", $signed(out_re), er);
            chk($signed(out_im) == ei, "R7", "imag estimate", $signed(out_im), ei);
          end else begin
            chk(!in_ready, "R8", "in_ready during stall", in_ready, 0);
            stalled = 1'b1;
            held_re = $signed(out_re);
            held_im = $signed(out_im);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      chk(1'b0, "R9", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NTAPS; j++) begin
      mre[j] = 0;
      mim[j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R3: ten pilots with data beats fill the line but give no estimate
    for (int s = 0; s < NTAPS - 1; s++) begin
      send(s * 300 - 1500, 1000 - s * 170, 1'b1, 0);
      for (int m = 1; m < SLOT_LEN; m++) send(m * 11, -m * 7, 1'b0, m);
    end
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R3", "no estimate before eleventh pilot", out_valid, 0);

    // Streaming slots; the eleventh pilot yields the first estimate (R3, R9)
    for (int s = 0; s < 30; s++) begin
      int pr, pi;
      if (s >= 8) ready_mode = 1;
      pr = int'($urandom % 65536) - 32768;
      pi = int'($urandom % 65536) - 32768;
      if (s == 3) begin pr = 32767; pi = -32768; end
      if (s == 4) begin pr = -32768; pi = 32767; end
      send(pr, pi, 1'b1, 0);
      for (int m = 1; m < SLOT_LEN; m++) send(m * 50, -m * 40, 1'b0, m);
      if (s % 5 == 2) begin
        send(123, -45, 1'b0, 7);   // R6
        send(999, 888, 1'b0, 0);   // R2: non-pilot, line unchanged
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    ready_mode = 0;
    for (int w = 0; w < 200 && exp_re_q.size() != 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_re_q.size() == 0, "R9", "pending estimates left", exp_re_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule